// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a wedged I2C or SMBus bus from the controller side. It is started by a one-cycle request. First it releases both lines and gives a slave that is stretching the clock a bounded number of half-bit intervals to let SCL go. If SDA is then high, the bus is already free. Otherwise the sequencer runs up to a fixed number of recovery rounds. Each round clocks SCL until the stuck slave releases SDA, up to a pulse limit, and then ends with a forced STOP. The bus counts as recovered when both lines read high after a round.

Both lines are handled as open-drain. The block only asserts pull-low enables, and it reads the real line levels through a two-stage synchronizer. All timing comes from one half-bit interval. Its length in clock cycles is worked out from the clock frequency, so a 5 µs half-bit (100 kHz) holds at any clock rate. When the procedure ends, `done` pulses for one cycle and two separate flags report whether SDA and SCL were still low.

Top module: `busRecover`

## Requirements
- R1: After reset, `busy`, `done`, `failSda`, `failScl`, `sclPullLow` and `sdaPullLow` are all 0.
- R2: A `start` pulse while idle raises `busy` for the whole procedure. `done` is high for exactly one cycle, in the same cycle that `busy` falls. A `start` that arrives while `busy` is high has no effect on timing or result.
- R3: SCL is checked at the end of each half-bit interval after `start`, at most SCL_TRIES times. If it is still low at the last check, the procedure ends with `failScl`=1 exactly SCL_TRIES half-bits after `start`, and no clock pulses or STOP are generated.
- R4: If SCL is seen high at check j and SDA is high, the procedure ends with both flags 0 exactly j half-bits after `start`, and no clock pulses are generated.
- R5: Within a round, each clock pulse pulls SCL low for one half-bit and then releases it for one half-bit. SDA is sampled at the end of each released half-bit, and clocking stops as soon as SDA reads high or MAX_PULSES pulses have been given.
- R6: Every round ends with SDA pulled low for one half-bit while SCL is released, then SDA released for one half-bit (a STOP). Exactly one such STOP is produced per round.
- R7: After each STOP, the procedure succeeds if SCL and SDA both read high. Otherwise another round starts, up to SDA_ROUNDS rounds. After the last failed round, `failSda` reports SDA low. For a slave that releases SDA after N rising SCL edges (1 ≤ N ≤ MAX_PULSES·SDA_ROUNDS), the total time is (1 + 2N + 2·ceil(N/MAX_PULSES)) half-bits.
- R8: One half-bit lasts CLK_HZ·HALF_US/1 000 000 clock cycles.
- R9: `sclPullLow` and `sdaPullLow` (1 = pull the line low, 0 = release) are never both 1 in the same cycle.
- R10: `failSda` and `failScl` keep their values from the end of one procedure until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin recovery |
| sclIn | input | 1 | Sampled SCL line level (asynchronous) |
| sdaIn | input | 1 | Sampled SDA line level (asynchronous) |
| sclPullLow | output | 1 | 1 = pull SCL low, 0 = release |
| sdaPullLow | output | 1 | 1 = pull SDA low, 0 = release |
| busy | output | 1 | High while recovery is in progress |
| done | output | 1 | One-cycle pulse at the end of recovery |
| failSda | output | 1 | SDA was low at the end |
| failScl | output | 1 | SCL was low at the end |

## Verification
Every result is due a whole number of half-bit intervals after the edge that accepts `start`. That number is H for an idle bus, j·H when a stretched clock is released at check j, SCL_TRIES·H for a clock stuck low, and (1+2N+2·rounds)·H for a slave that frees SDA after N edges. The bench counts falling clock edges from the accepting edge to the first sample of `done` and compares the count with these figures. Line changes from the modelled slave are made mid-cycle and at least three cycles before the check that has to see them, so the two synchronizer stages never make the timing ambiguous. Pulse and STOP counts are taken from the pull-low outputs, and the flags are read again several cycles after `done` to confirm that they hold.

// File: rtl/busRecoverPkg.sv
package busRecoverPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_SCL,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_STOP_LO,
    ST_STOP_HI
  } recState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic tickClr;
    logic cntClr;
    logic tryInc;
    logic pulseInc;
    logic pulseClr;
    logic roundInc;
  } recCtl_t;

  // datapath -> control status
  typedef struct packed {
    logic tick;
    logic sclHigh;
    logic sdaHigh;
    logic tryLast;
    logic pulseLast;
    logic roundLast;
  } recStat_t;

endpackage

// File: rtl/busRecoverDp.sv
module busRecoverDp
  import busRecoverPkg::*;
#(
  parameter int HALF_CYC   = 625,
  parameter int SCL_TRIES  = 10,
  parameter int SDA_ROUNDS = 3,
  parameter int MAX_PULSES = 9
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclIn,
  input  logic     sdaIn,
  input  recCtl_t  ctl,
  output recStat_t stat
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int TW = $clog2(SCL_TRIES + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam int RW = $clog2(SDA_ROUNDS + 1);
  localparam logic [CW-1:0] CNT_LAST   = CW'(HALF_CYC - 1);
  localparam logic [TW-1:0] TRY_LAST   = TW'(SCL_TRIES - 1);
  localparam logic [TW-1:0] TRY_MAX    = TW'(SCL_TRIES);
  localparam logic [PW-1:0] PULSE_LAST = PW'(MAX_PULSES - 1);
  localparam logic [PW-1:0] PULSE_MAX  = PW'(MAX_PULSES);
  localparam logic [RW-1:0] ROUND_LAST = RW'(SDA_ROUNDS - 1);
  localparam logic [RW-1:0] ROUND_MAX  = RW'(SDA_ROUNDS);

  // two-stage synchronizer for both lines, index 1 = SCL, 0 = SDA
  logic [1:0] lineRaw;
  logic [1:0] syncStage [2];
  assign lineRaw = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[g] <= 2'b11;
      else       syncStage[g] <= (g == 0) ? lineRaw : syncStage[0];
    end
  end

  // half-bit timer
  logic [CW-1:0] halfCnt;
  logic          tick;
  assign tick = (halfCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    halfCnt <= '0;
    else if (ctl.tickClr || tick) halfCnt <= '0;
    else                          halfCnt <= halfCnt + 1'b1;
  end

  // attempt counters
  logic [TW-1:0] tryCnt;
  logic [PW-1:0] pulseCnt;
  logic [RW-1:0] roundCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tryCnt   <= '0;
      pulseCnt <= '0;
      roundCnt <= '0;
    end else if (ctl.cntClr) begin
      tryCnt   <= '0;
      pulseCnt <= '0;
      roundCnt <= '0;
    end else begin
      if (ctl.tryInc)   tryCnt   <= tryCnt + 1'b1;
      if (ctl.pulseClr) pulseCnt <= '0;
      else if (ctl.pulseInc) pulseCnt <= pulseCnt + 1'b1;
      if (ctl.roundInc) roundCnt <= roundCnt + 1'b1;
    end
  end

  assign stat.tick      = tick;
  assign stat.sclHigh   = syncStage[1][1];
  assign stat.sdaHigh   = syncStage[1][0];
  assign stat.tryLast   = (tryCnt == TRY_LAST);
  assign stat.pulseLast = (pulseCnt == PULSE_LAST);
  assign stat.roundLast = (roundCnt == ROUND_LAST);

  a_r3_try_bound: assert property (@(posedge clk) disable iff (!rstN)
    tryCnt <= TRY_MAX);
  a_r5_pulse_bound: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PULSE_MAX);
  a_r7_round_bound: assert property (@(posedge clk) disable iff (!rstN)
    roundCnt <= ROUND_MAX);
  a_r8_strobe_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pulseInc || ctl.roundInc || ctl.tryInc) |-> tick);

endmodule

// File: rtl/busRecoverCtl.sv
module busRecoverCtl
  import busRecoverPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  recStat_t stat,
  output recCtl_t  ctl,
  output logic     sclPullLow,
  output logic     sdaPullLow,
  output logic     busy,
  output logic     done,
  output logic     failSda,
  output logic     failScl
);
  recState_t state;
  logic      bothHigh;
  assign bothHigh = stat.sclHigh && stat.sdaHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      failSda <= 1'b0;
      failScl <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_WAIT_SCL;
          busy    <= 1'b1;
          failSda <= 1'b0;
          failScl <= 1'b0;
        end
        ST_WAIT_SCL: if (stat.tick) begin
          if (stat.sclHigh) begin
            if (stat.sdaHigh) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              state <= ST_CLK_LO;
            end
          end else if (stat.tryLast) begin
            state   <= ST_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
            failScl <= 1'b1;
            failSda <= !stat.sdaHigh;
          end
        end
        ST_CLK_LO: if (stat.tick) state <= ST_CLK_HI;
        ST_CLK_HI: if (stat.tick) begin
          if (stat.sdaHigh || stat.pulseLast) state <= ST_STOP_LO;
          else                                state <= ST_CLK_LO;
        end
        ST_STOP_LO: if (stat.tick) state <= ST_STOP_HI;
        ST_STOP_HI: if (stat.tick) begin
          if (bothHigh || stat.roundLast) begin
            state   <= ST_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
            failSda <= !stat.sdaHigh;
            failScl <= !stat.sclHigh;
          end else if (stat.sdaHigh) begin
            state <= ST_STOP_LO;
          end else begin
            state <= ST_CLK_LO;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE: begin
        ctl.tickClr = start;
        ctl.cntClr  = start;
      end
      ST_WAIT_SCL: ctl.tryInc = stat.tick && !stat.sclHigh;
      ST_CLK_HI:   ctl.pulseInc = stat.tick;
      ST_STOP_HI: begin
        ctl.roundInc = stat.tick && !bothHigh && !stat.roundLast;
        ctl.pulseClr = ctl.roundInc;
      end
      default: ;
    endcase
  end

  assign sclPullLow = (state == ST_CLK_LO);
  assign sdaPullLow = (state == ST_STOP_LO);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  a_r9_one_line: assert property (@(posedge clk) disable iff (!rstN)
    !(sclPullLow && sdaPullLow));
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable({failSda, failScl}));
  a_r6_stop_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> (busy && $past(stat.tick)));

endmodule

// File: rtl/busRecover.sv
module busRecover
  import busRecoverPkg::*;
#(
  parameter int CLK_HZ     = 125_000_000,
  parameter int HALF_US    = 5,
  parameter int SCL_TRIES  = 10,
  parameter int SDA_ROUNDS = 3,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclPullLow,
  output logic sdaPullLow,
  output logic busy,
  output logic done,
  output logic failSda,
  output logic failScl
);
  localparam longint HALF_L   = longint'(CLK_HZ) * HALF_US / 1_000_000;
  localparam int     HALF_CYC = (HALF_L < 4) ? 4 : int'(HALF_L);

  recCtl_t  ctl;
  recStat_t stat;

  busRecoverDp #(
    .HALF_CYC  (HALF_CYC),
    .SCL_TRIES (SCL_TRIES),
    .SDA_ROUNDS(SDA_ROUNDS),
    .MAX_PULSES(MAX_PULSES)
  ) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .ctl  (ctl),
    .stat (stat)
  );

  busRecoverCtl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .stat      (stat),
    .ctl       (ctl),
    .sclPullLow(sclPullLow),
    .sdaPullLow(sdaPullLow),
    .busy      (busy),
    .done      (done),
    .failSda   (failSda),
    .failScl   (failScl)
  );

endmodule

// File: tb/busRecover_bench.sv
module busRecover_bench;
  localparam int CLK_HZ = 800_000;
  localparam int H      = CLK_HZ * 5 / 1_000_000;   // R8: 4 cycles
  localparam int TRIES  = 10;
  localparam int ROUNDS = 3;
  localparam int PULSES = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic sclHold = 1'b0;
  logic countEn = 1'b0;
  int   needRises = 0;
  logic sclPullLow, sdaPullLow, busy, done, failSda, failScl;
  logic sclWire, sdaWire, sdaHold;
  int   riseCnt = 0, pulseCnt = 0, stopCnt = 0, cycles = 0;
  logic prevScl = 1'b1, prevSclPull = 1'b0, prevSdaPull = 1'b0;
  int   checks = 0, errors = 0;

  always #4 clk = ~clk;

  assign sdaHold = (riseCnt < needRises);
  assign sclWire = !(sclPullLow || sclHold);
  assign sdaWire = !(sdaPullLow || sdaHold);

  busRecover #(.CLK_HZ(CLK_HZ), .SCL_TRIES(TRIES), .SDA_ROUNDS(ROUNDS),
               .MAX_PULSES(PULSES)) u_busRecover (
    .clk(clk), .rstN(rstN), .start(start), .sclIn(sclWire), .sdaIn(sdaWire),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow), .busy(busy),
    .done(done), .failSda(failSda), .failScl(failScl));

  // slave model and bus monitors
  always @(posedge clk) begin
    cycles      <= cycles + 1;
    prevScl     <= sclWire;
    prevSclPull <= sclPullLow;
    prevSdaPull <= sdaPullLow;
    if (!countEn) begin
      riseCnt <= 0; pulseCnt <= 0; stopCnt <= 0;
    end else begin
      if (sclWire && !prevScl) riseCnt <= riseCnt + 1;
      if (prevSclPull && !sclPullLow) pulseCnt <= pulseCnt + 1;
      if (prevSdaPull && !sdaPullLow && sclWire) stopCnt <= stopCnt + 1;
    end
  end

  always @(posedge clk) begin
    if (cycles > 150_000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sclRelJ: 0 = SCL free, j>0 = released before check j (j>TRIES never)
  task automatic runCase(input int sclRelJ, input int need, input bit restart,
                         input int expLat, input int expSda, input int expScl,
                         input int expPulse, input int expStop, input string tag);
    int lat;
    @(negedge clk);
    needRises = need;
    sclHold   = (sclRelJ != 0);
    countEn   = 1'b1;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 400) begin
      if (sclRelJ != 0 && lat == (sclRelJ - 1) * H + 1) sclHold = 1'b0;
      if (restart && lat == 2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (lat == 1) chk({"R2 busy ", tag}, busy, 1);
    end
    chk({"R2/R3/R4/R7 latency ", tag}, lat, expLat);
    chk({"R7 failSda ", tag}, failSda, expSda);
    chk({"R3 failScl ", tag}, failScl, expScl);
    chk({"R5 pulses ", tag}, pulseCnt, expPulse);
    chk({"R6 stops ", tag}, stopCnt, expStop);
    @(negedge clk);
    chk({"R2 done single ", tag}, done, 0);
    repeat (4) @(negedge clk);
    chk({"R10 flags hold ", tag}, {30'd0, failSda, failScl}, expSda * 2 + expScl);
    sclHold   = 1'b0;
    needRises = 0;
    countEn   = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs",
        {26'd0, busy, done, failSda, failScl, sclPullLow, sdaPullLow}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {30'd0, busy, done}, 0);

    // R4: idle bus, no clocks
    runCase(0, 0, 1'b0, H, 0, 0, 0, 0, "idle");
    // R2: start during busy ignored
    runCase(0, 5, 1'b1, H + 2 * 5 * H + 2 * H, 0, 0, 5, 1, "restart");

    // R3/R4 sweep of clock stretch release point
    for (int j = 1; j <= TRIES + 1; j++) begin
      if (j <= TRIES) runCase(j, 0, 1'b0, j * H, 0, 0, 0, 0, "stretch");
      else            runCase(j, 0, 1'b0, TRIES * H, 0, 1, 0, 0, "scl stuck");
    end
    // R3: both lines stuck
    runCase(TRIES + 1, 1000, 1'b0, TRIES * H, 1, 1, 0, 0, "both stuck");

    // R5/R6/R7 sweep of SDA release edge count
    for (int n = 1; n <= PULSES * ROUNDS + 2; n++) begin
      int r;
      r = (n + PULSES - 1) / PULSES;
      if (n <= PULSES * ROUNDS)
        runCase(0, n, 1'b0, H + 2 * n * H + 2 * r * H, 0, 0, n, r, "sda release");
      else
        runCase(0, n, 1'b0, H + 2 * PULSES * ROUNDS * H + 2 * ROUNDS * H,
                1, 0, PULSES * ROUNDS, ROUNDS, "sda stuck");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule